// File: doc/BRIEF.md
# Serial Transmitter with Bypassable Byte Queue

This block turns bytes written by a host into an asynchronous serial stream. Written bytes land in a holding area. With queueing enabled, the holding area is a 32-entry first-in first-out buffer. With queueing disabled, it is a single byte register. An 8-bit shift register takes the oldest held byte and sends it out as one frame. A frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits.

Bit timing comes from an external baud generator. That generator supplies a single-cycle `bit_tick_i` pulse once per bit time, meaning once every 16, 8 or 4 oversampling clocks. Every change on the line happens in the cycle after such a pulse.

The block has two empty flags. The first shows that the holding area is empty. The second shows that the whole transmitter is empty, meaning the holding area and the shift register both have nothing left to send. Receive logic, interrupts and bus decoding sit outside this block.

Top module: `serial_tx_core`

## Requirements
- R1: After reset, `tx_o` is 1 and both `hold_empty_o` and `tx_empty_o` are 1. The line stays 1 whenever the transmitter is empty.
- R2: A frame is a start bit of 0, then N data bits with bit 0 of the byte first, then the stop bits at 1. N is 5, 6, 7 or 8 for `data_bits_i` values 0, 1, 2 and 3.
- R3: When `parity_en_i` is 1, a parity bit follows the last data bit. It equals the XOR of the N active data bits when `parity_odd_i` is 0 (even parity), and the inverse of that XOR when `parity_odd_i` is 1 (odd parity).
- R4: When `two_stop_i` is 0 the frame ends with one stop bit; when it is 1 the frame ends with two stop bits.
- R5: A frame starts only on a cycle with `bit_tick_i` high. `tx_o` changes only in the cycle after a `bit_tick_i` pulse, so each bit lasts exactly one tick interval.
- R6: When `fifo_en_i` is 1, up to 32 written bytes are held and sent in write order. A write made while 32 bytes are held is discarded and leaves the stored bytes unchanged.
- R7: When `fifo_en_i` is 0, only one byte is held. A write made while that byte is still waiting is discarded.
- R8: When a byte is waiting at the tick that ends the last stop bit, the start bit of the next frame follows at once, with no idle bit in between.
- R9: `hold_empty_o` is 1 exactly when no byte is waiting in the holding area. `tx_empty_o` is 1 only when the holding area is empty and no frame is in progress.
- R10: A change of `fifo_en_i` empties the holding area on the next clock edge. Any write in that same cycle is dropped, and the discarded bytes are never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 8 | Byte to send |
| fifo_en_i | input | 1 | 1 selects the 32-entry queue; 0 selects the single holding register |
| data_bits_i | input | 2 | Data bit count minus 5 |
| parity_en_i | input | 1 | Adds a parity bit to the frame |
| parity_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| two_stop_i | input | 1 | 1 selects two stop bits |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| tx_o | output | 1 | Serial line |
| hold_empty_o | output | 1 | Holding area empty |
| tx_empty_o | output | 1 | Holding area and shift register both empty |

## Verification
The bench sweeps all 24 frame shapes with several byte values. This catches a wrong data-bit count, a parity bit with the wrong sense, or a parity computed over unused high bits; each of those shows up as a bit-stream mismatch. A design that idles for a bit between queued frames fails the back-to-back comparison. A design whose line moves between ticks fails the stability count.

The remaining checks target the holding area. They fill the queue to 33 writes and overfill the single register, which exposes a design that overwrites stored data or sends extra bytes. They also switch the queue mode while bytes are held, which exposes a design that still transmits stale data after the switch.

// File: rtl/serial_tx_pkg.sv
`timescale 1ns/1ps
package serial_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/tx_hold_fifo.sv
`timescale 1ns/1ps
module tx_hold_fifo #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         queue_mode_i,
  input  logic                         push_i,
  input  logic [W-1:0]                 data_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 data_o,
  output logic                         empty_o,
  output logic [$clog2(DEPTH+1)-1:0]   fill_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count, cap;
  logic          full, push_ok, pop_ok;

  assign cap     = queue_mode_i ? CW'(DEPTH) : CW'(1);
  assign full    = count >= cap;
  assign empty_o = count == '0;
  assign push_ok = push_i && !full && !flush_i;
  assign pop_ok  = pop_i && !empty_o && !flush_i;
  assign data_o  = mem[rptr];
  assign fill_o  = count;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush_i) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/tx_frame_shifter.sv
`timescale 1ns/1ps
module tx_frame_shifter
  import serial_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              avail_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [1:0]        data_bits_i,
  input  logic              parity_en_i,
  input  logic              parity_odd_i,
  input  logic              two_stop_i,
  output logic              pop_o,
  output logic              tx_o,
  output logic              idle_o
);
  tx_state_e         state;
  logic [BYTE_W-1:0] sh;
  logic [2:0]        cnt, last_idx;
  logic              par_q, pen_q, two_q, stop_cnt;
  logic              last_stop, frame_end;
  logic [BYTE_W-1:0] mask;

  assign mask      = 8'hFF >> (2'd3 - data_bits_i);
  assign last_stop = !two_q || stop_cnt;
  assign frame_end = (state == ST_IDLE) || (state == ST_STOP && last_stop);
  assign pop_o     = tick_i && avail_i && frame_end;
  assign idle_o    = state == ST_IDLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      tx_o     <= 1'b1;
      sh       <= '0;
      cnt      <= '0;
      last_idx <= '0;
      par_q    <= 1'b0;
      pen_q    <= 1'b0;
      two_q    <= 1'b0;
      stop_cnt <= 1'b0;
    end else if (tick_i) begin
      unique case (state)
        ST_IDLE, ST_STOP: begin
          if (state == ST_STOP && !last_stop) begin
            stop_cnt <= 1'b1;
          end else if (avail_i) begin
            // settings are latched per frame
            state    <= ST_START;
            tx_o     <= 1'b0;
            sh       <= data_i;
            last_idx <= {1'b1, data_bits_i};
            par_q    <= ^(data_i & mask) ^ parity_odd_i;
            pen_q    <= parity_en_i;
            two_q    <= two_stop_i;
            stop_cnt <= 1'b0;
          end else begin
            state <= ST_IDLE;
            tx_o  <= 1'b1;
          end
        end
        ST_START: begin
          tx_o  <= sh[0];
          sh    <= sh >> 1;
          cnt   <= '0;
          state <= ST_DATA;
        end
        ST_DATA: begin
          if (cnt == last_idx) begin
            if (pen_q) begin
              tx_o  <= par_q;
              state <= ST_PAR;
            end else begin
              tx_o  <= 1'b1;
              state <= ST_STOP;
            end
          end else begin
            tx_o <= sh[0];
            sh   <= sh >> 1;
            cnt  <= cnt + 1'b1;
          end
        end
        ST_PAR: begin
          tx_o  <= 1'b1;
          state <= ST_STOP;
        end
        default: begin
          state <= ST_IDLE;
          tx_o  <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/serial_tx_core.sv
`timescale 1ns/1ps
module serial_tx_core
  import serial_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              fifo_en_i,
  input  logic [1:0]        data_bits_i,
  input  logic              parity_en_i,
  input  logic              parity_odd_i,
  input  logic              two_stop_i,
  input  logic              bit_tick_i,
  output logic              tx_o,
  output logic              hold_empty_o,
  output logic              tx_empty_o
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic              en_q, flush, avail, pop, empty, idle;
  logic [BYTE_W-1:0] head;
  logic [CW-1:0]     fill;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= fifo_en_i;
  end

  assign flush = fifo_en_i ^ en_q;
  assign avail = !empty && !flush;

  tx_hold_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush),
    .queue_mode_i (en_q),
    .push_i       (wr_en_i),
    .data_i       (wr_data_i),
    .pop_i        (pop),
    .data_o       (head),
    .empty_o      (empty),
    .fill_o       (fill)
  );

  tx_frame_shifter u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (bit_tick_i),
    .avail_i      (avail),
    .data_i       (head),
    .data_bits_i  (data_bits_i),
    .parity_en_i  (parity_en_i),
    .parity_odd_i (parity_odd_i),
    .two_stop_i   (two_stop_i),
    .pop_o        (pop),
    .tx_o         (tx_o),
    .idle_o       (idle)
  );

  assign hold_empty_o = empty;
  assign tx_empty_o   = empty && idle;
endmodule

// File: rtl/serial_tx_core_chk.sv
`timescale 1ns/1ps
module serial_tx_core_chk #(
  parameter int unsigned DEPTH = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       wr_en_i,
  input logic                       bit_tick_i,
  input logic                       tx_o,
  input logic                       hold_empty_o,
  input logic                       tx_empty_o,
  input logic                       flush_i,
  input logic                       pop_i,
  input logic                       mode_q_i,
  input logic [$clog2(DEPTH+1)-1:0] fill_i
);
  localparam int unsigned CW = $clog2(DEPTH+1);
  logic [CW-1:0] cap;
  assign cap = mode_q_i ? CW'(DEPTH) : CW'(1);

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> tx_o); // R1
  AST_EMPTY_NESTING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> hold_empty_o); // R9
  AST_LINE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_tick_i |=> $stable(tx_o)); // R5
  AST_POP_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> bit_tick_i); // R5
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i == cap && wr_en_i && !pop_i && !flush_i) |=> fill_i == $past(fill_i)); // R6
  AST_FILL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i <= cap); // R7
  AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> hold_empty_o); // R10
endmodule

bind serial_tx_core serial_tx_core_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .bit_tick_i   (bit_tick_i),
  .tx_o         (tx_o),
  .hold_empty_o (hold_empty_o),
  .tx_empty_o   (tx_empty_o),
  .flush_i      (flush),
  .pop_i        (pop),
  .mode_q_i     (en_q),
  .fill_i       (fill)
);

// File: tb/tb_serial_tx_core.sv
`timescale 1ns/1ps
module tb_serial_tx_core;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int MAXB       = 4096;

  logic clk = 0, rst_ni = 0;
  logic wr_en = 0, fifo_en = 0, par_en = 0, par_odd = 0, two_stop = 0, bit_tick = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] dbits = 0;
  logic tx, hold_empty, tx_empty;

  int checks = 0, errors = 0;
  bit tick_on = 0;
  int phase = 0, stab_err = 0;
  logic last_tx = 1'b1;
  bit log_bits [MAXB];
  int log_n = 0;
  bit exp_bits [MAXB];
  int exp_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_tx_core dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .fifo_en_i(fifo_en), .data_bits_i(dbits), .parity_en_i(par_en),
    .parity_odd_i(par_odd), .two_stop_i(two_stop), .bit_tick_i(bit_tick),
    .tx_o(tx), .hold_empty_o(hold_empty), .tx_empty_o(tx_empty)
  );

  // tick generator, line sampler and R5 stability monitor
  initial forever begin
    @(negedge clk);
    if (bit_tick) begin
      bit_tick = 0;
      if (log_n < MAXB) log_bits[log_n] = tx;
      log_n++;
      last_tx = tx;
    end else if (tx !== last_tx) begin
      stab_err++;
      last_tx = tx;
    end
    if (tick_on) begin
      phase++;
      if (phase == TICK_DIV) begin phase = 0; bit_tick = 1; end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    finish_run();
  end

  task automatic check(input bit ok, input string msg, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_en = 1; wr_data = b;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic add_frame(input logic [7:0] d, input int nb, input bit pen, input bit odd, input bit two);
    bit p;
    p = odd;
    exp_bits[exp_n++] = 0;
    for (int i = 0; i < nb; i++) begin
      exp_bits[exp_n++] = d[i];
      p ^= d[i];
    end
    if (pen) exp_bits[exp_n++] = p;
    exp_bits[exp_n++] = 1;
    if (two) exp_bits[exp_n++] = 1;
  endtask

  task automatic start_ticks();
    @(negedge clk); log_n = 0; tick_on = 1;
  endtask

  task automatic stop_ticks();
    tick_on = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_until_empty();
    start_ticks();
    do @(negedge clk); while (!tx_empty);
    repeat (3*TICK_DIV) @(negedge clk);
    stop_ticks();
  endtask

  task automatic compare_stream(input string tag);
    int bad;
    bad = -1;
    if (log_n < exp_n) bad = log_n;
    for (int i = 0; i < exp_n && i < log_n && bad < 0; i++)
      if (log_bits[i] != exp_bits[i]) bad = i;
    for (int i = exp_n; i < log_n && i < MAXB && bad < 0; i++)
      if (log_bits[i] != 1'b1) bad = i;
    check(bad < 0, tag, bad, -1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tx === 1'b1, "R1 reset tx", int'(tx), 1);
    check(hold_empty === 1'b1 && tx_empty === 1'b1, "R1 R9 reset flags",
          int'({hold_empty, tx_empty}), 3);
    rst_ni = 1;
    @(negedge clk);
    fifo_en = 1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R8 sweep of all frame shapes, three queued bytes each
    for (int db = 0; db < 4; db++)
      for (int pm = 0; pm < 3; pm++)
        for (int ts = 0; ts < 2; ts++) begin
          dbits = 2'(db); par_en = (pm != 0); par_odd = (pm == 2); two_stop = ts[0];
          exp_n = 0;
          for (int j = 0; j < 3; j++) begin
            logic [7:0] d;
            d = 8'(db*53 + pm*29 + ts*101 + j*71 + 7);
            wr(d);
            add_frame(d, db + 5, par_en, par_odd, two_stop);
          end
          @(negedge clk);
          check(!hold_empty && !tx_empty, "R9 flags with queued bytes",
                int'({hold_empty, tx_empty}), 0);
          run_until_empty();
          compare_stream($sformatf("R2 R3 R4 R8 stream db=%0d pm=%0d ts=%0d first bad bit", db, pm, ts));
        end

    // R6 fill queue with 33 writes, last one dropped
    dbits = 2'd3; par_en = 0; par_odd = 0; two_stop = 0;
    exp_n = 0;
    for (int i = 0; i < 33; i++) begin
      wr(8'(i*7 + 1));
      if (i < 32) add_frame(8'(i*7 + 1), 8, 0, 0, 0);
    end
    run_until_empty();
    compare_stream("R6 full queue drops 33rd write, first bad bit");

    // R10 mode change clears held bytes; write in the same cycle is dropped
    wr(8'h11); wr(8'h22); wr(8'h33);
    @(negedge clk);
    check(!hold_empty, "R6 bytes held before switch", int'(hold_empty), 0);
    fifo_en = 0; wr_en = 1; wr_data = 8'h44;
    @(negedge clk); wr_en = 0;
    @(negedge clk);
    check(hold_empty === 1'b1 && tx_empty === 1'b1, "R10 switch empties holding area",
          int'({hold_empty, tx_empty}), 3);
    start_ticks();
    repeat (40*TICK_DIV) @(negedge clk);
    stop_ticks();
    exp_n = 0;
    compare_stream("R10 no stale frame after switch, first bad bit");

    // R7 single register: second write while held is dropped
    exp_n = 0;
    wr(8'hA5); wr(8'h3C);
    add_frame(8'hA5, 8, 0, 0, 0);
    run_until_empty();
    compare_stream("R7 bypass drops write to occupied register, first bad bit");

    // R7 R8 R9 write while shifting: one accepted, back-to-back, third dropped
    exp_n = 0;
    wr(8'h5A);
    add_frame(8'h5A, 8, 0, 0, 0);
    start_ticks();
    do @(negedge clk); while (!hold_empty);
    check(tx_empty === 1'b0, "R9 busy shifter with empty holding", int'(tx_empty), 0);
    wr(8'hC3); wr(8'h0F);
    add_frame(8'hC3, 8, 0, 0, 0);
    do @(negedge clk); while (!tx_empty);
    repeat (3*TICK_DIV) @(negedge clk);
    stop_ticks();
    compare_stream("R7 R8 bypass refill during frame, first bad bit");

    check(stab_err == 0, "R5 line moved between ticks", stab_err, 0);
    check(tx === 1'b1 && tx_empty === 1'b1, "R1 idle line after traffic", int'(tx), 1);
    finish_run();
  end
endmodule